// File: doc/BRIEF.md
# DMA Channel Layer Register Block

This block holds the control and status registers of a multi-channel memory access layer. The layer serves up to 32 transmit and up to 32 receive channels. It stores a global configuration word, an error status word, an interrupt enable word, and per-direction channel-active set and reset words. It also keeps per-direction end-of-buffer and descriptor-error status, one descriptor table pointer per channel, and one buffer-size byte per receive channel. The descriptor engine sets status bits through single-cycle event inputs. Software reads and writes every register through a plain addressed port.

Four interrupt lines are formed from the status registers gated by the enable word. Writing the configuration word with its top bit set is a software reset of the control and status set, and the value written is not stored. The pointer and buffer-size ranges are sized by the two channel-count parameters. Addresses past the configured count behave as if unmapped. There is no sequencing logic, so the block has no state machine: each register is a direct function of the port and the event inputs.

Top module: `dmac_reg_block`

## Requirements
- R1: After rst_n is low, configuration reads 0x0007C000. Every other register reads 0, including pointers and buffer sizes, and all four interrupt outputs are 0.
- R2: A configuration write (address 0x180) with wdata bit 31 clear stores wdata AND 0x00FFC087.
- R3: A configuration write with wdata bit 31 set is a software reset. Configuration returns to 0x0007C000. Error status, interrupt enable, all four channel-active words, both end-of-buffer words and both descriptor-error words become 0. Pointers and buffer sizes keep their values, and wdata is not stored.
- R4: Interrupt enable (0x182) keeps only wdata bits 4:0. Bit 0 gates error, bit 1 transmit end-of-buffer, bit 2 receive end-of-buffer, bit 3 transmit descriptor-error and bit 4 receive descriptor-error.
- R5: The transmit active set (0x184) and reset (0x185) words keep wdata bits 31:28. The receive active set (0x190) and reset (0x191) words keep bits 31:30.
- R6: End-of-buffer status, transmit at 0x186 and receive at 0x192, is write-1-to-clear. A pulse on event input bit c sets status bit 31-c. A set and a clear of the same bit in the same cycle leave the bit set.
- R7: Descriptor-error status (transmit 0x187, receive 0x193) behaves as in R6. Error status (0x181) is also write-1-to-clear, and err_set bit i sets its bit i.
- R8: The transmit pointer of channel c is at 0x1A0+c and the receive pointer of channel c is at 0x1C0+c. All 32 bits are stored.
- R9: The receive buffer size of channel c is at 0x1E0+c and keeps wdata bits 7:0.
- R10: Pointer and buffer-size addresses at or past the channel count are not decoded. These addresses, and every other unlisted address, read 0 and ignore writes.
- R11: irq_err is high when error status and enable bit 0 are both non-zero. irq_tx_eob uses enable bit 1 and irq_rx_eob uses enable bit 2. irq_derr is (transmit descriptor-error and bit 3) OR (receive descriptor-error and bit 4). Each output follows the registers after the edge that updates them.
- R12: A read sampled with rd_en at a clock edge puts the pre-edge register value on rdata after that edge. rdata holds while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 10 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| tx_eob_set | input | TXN | Transmit end-of-buffer events, one per channel |
| rx_eob_set | input | RXN | Receive end-of-buffer events, one per channel |
| tx_derr_set | input | TXN | Transmit descriptor-error events |
| rx_derr_set | input | RXN | Receive descriptor-error events |
| err_set | input | 32 | Error status set bits |
| irq_err | output | 1 | Error interrupt |
| irq_tx_eob | output | 1 | Transmit end-of-buffer interrupt |
| irq_rx_eob | output | 1 | Receive end-of-buffer interrupt |
| irq_derr | output | 1 | Descriptor-error interrupt |

## Verification
A write or an event pulse takes effect at the rising edge that samples it. The interrupt outputs reflect that update right after the same edge. Read data comes out one register later, so it is valid after the edge that samples rd_en. The bench drives every input on the falling edge and samples the outputs on the next falling edge, which is the earliest point at which each result is due.

// File: rtl/dmac_regs_pkg.sv
package dmac_regs_pkg;
    localparam int AW = 10;
    localparam int DW = 32;

    localparam logic [AW-1:0] A_CFG   = 10'h180;
    localparam logic [AW-1:0] A_ERR   = 10'h181;
    localparam logic [AW-1:0] A_IEN   = 10'h182;
    localparam logic [AW-1:0] A_TXSET = 10'h184;
    localparam logic [AW-1:0] A_TXCLR = 10'h185;
    localparam logic [AW-1:0] A_TXEOB = 10'h186;
    localparam logic [AW-1:0] A_TXDER = 10'h187;
    localparam logic [AW-1:0] A_RXSET = 10'h190;
    localparam logic [AW-1:0] A_RXCLR = 10'h191;
    localparam logic [AW-1:0] A_RXEOB = 10'h192;
    localparam logic [AW-1:0] A_RXDER = 10'h193;
    localparam logic [AW-1:0] A_TXPTR = 10'h1A0;
    localparam logic [AW-1:0] A_RXPTR = 10'h1C0;
    localparam logic [AW-1:0] A_RXBSZ = 10'h1E0;

    localparam logic [DW-1:0] CFG_RST     = 32'h0007_C000;
    localparam logic [DW-1:0] CFG_WMASK   = 32'h00FF_C087;
    localparam logic [DW-1:0] IEN_WMASK   = 32'h0000_001F;
    localparam logic [DW-1:0] TXACT_WMASK = 32'hF000_0000;
    localparam logic [DW-1:0] RXACT_WMASK = 32'hC000_0000;
    localparam logic [DW-1:0] BSZ_WMASK   = 32'h0000_00FF;
    localparam logic [DW-1:0] FULL_WMASK  = 32'hFFFF_FFFF;

    localparam int SWRST_BIT = 31;

    typedef enum int {
        IE_ERR   = 0,
        IE_TXEOB = 1,
        IE_RXEOB = 2,
        IE_TXDER = 3,
        IE_RXDER = 4
    } ien_bit_e;
endpackage

// File: rtl/dmac_chan_bank.sv
module dmac_chan_bank
    import dmac_regs_pkg::*;
#(
    parameter int            N     = 4,
    parameter logic [AW-1:0] BASE  = A_TXPTR,
    parameter logic [DW-1:0] DMASK = FULL_WMASK
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          hit,
    output logic [DW-1:0] rd_val
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [DW-1:0] regs [N];
    logic [AW-1:0] off;

    assign off = addr - BASE;
    assign hit = (addr >= BASE) && (off < AW'(N));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < N; c++) regs[c] <= '0;
        end else if (wr_en && hit) begin
            for (int c = 0; c < N; c++)
                if (off == AW'(c)) regs[c] <= wdata & DMASK;
        end
    end

    always_comb begin
        rd_val = '0;
        for (int c = 0; c < N; c++)
            if (hit && off[IW-1:0] == IW'(c)) rd_val = regs[c];
    end
endmodule

// File: rtl/dmac_w1c_status.sv
module dmac_w1c_status
    import dmac_regs_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_clr,
    input  logic          clr_we,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] set_bits,
    output logic [DW-1:0] q
);
    logic [DW-1:0] clr_bits;

    assign clr_bits = clr_we ? wdata : '0;

    always_ff @(posedge clk) begin
        if (!rst_n || sw_clr) q <= '0;
        else                  q <= (q & ~clr_bits) | set_bits;
    end
endmodule

// File: rtl/dmac_reg_block.sv
module dmac_reg_block
    import dmac_regs_pkg::*;
#(
    parameter int TXN = 4,
    parameter int RXN = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           rd_en,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata,
    input  logic [TXN-1:0] tx_eob_set,
    input  logic [RXN-1:0] rx_eob_set,
    input  logic [TXN-1:0] tx_derr_set,
    input  logic [RXN-1:0] rx_derr_set,
    input  logic [DW-1:0]  err_set,
    output logic           irq_err,
    output logic           irq_tx_eob,
    output logic           irq_rx_eob,
    output logic           irq_derr
);
    logic          swrst;
    logic [DW-1:0] cfg_q, ien_q, txset_q, txclr_q, rxset_q, rxclr_q;
    logic [DW-1:0] err_q, tx_eob_q, rx_eob_q, tx_der_q, rx_der_q;
    logic [DW-1:0] tx_eob_bits, rx_eob_bits, tx_der_bits, rx_der_bits;
    logic          txp_hit, rxp_hit, bsz_hit, decoded;
    logic [DW-1:0] txp_val, rxp_val, bsz_val, rd_mux;

    assign swrst = wr_en && (addr == A_CFG) && wdata[SWRST_BIT];

    // channel c event maps to status bit 31-c
    always_comb begin
        tx_eob_bits = '0;
        tx_der_bits = '0;
        rx_eob_bits = '0;
        rx_der_bits = '0;
        for (int c = 0; c < TXN; c++) begin
            tx_eob_bits[DW-1-c] = tx_eob_set[c];
            tx_der_bits[DW-1-c] = tx_derr_set[c];
        end
        for (int c = 0; c < RXN; c++) begin
            rx_eob_bits[DW-1-c] = rx_eob_set[c];
            rx_der_bits[DW-1-c] = rx_derr_set[c];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || swrst) begin
            cfg_q   <= CFG_RST;
            ien_q   <= '0;
            txset_q <= '0;
            txclr_q <= '0;
            rxset_q <= '0;
            rxclr_q <= '0;
        end else if (wr_en) begin
            unique case (addr)
                A_CFG:   cfg_q   <= wdata & CFG_WMASK;
                A_IEN:   ien_q   <= wdata & IEN_WMASK;
                A_TXSET: txset_q <= wdata & TXACT_WMASK;
                A_TXCLR: txclr_q <= wdata & TXACT_WMASK;
                A_RXSET: rxset_q <= wdata & RXACT_WMASK;
                A_RXCLR: rxclr_q <= wdata & RXACT_WMASK;
                default: ;
            endcase
        end
    end

    dmac_w1c_status u_err (.clk, .rst_n, .sw_clr(swrst),
        .clr_we(wr_en && addr == A_ERR), .wdata, .set_bits(err_set), .q(err_q));
    dmac_w1c_status u_txeob (.clk, .rst_n, .sw_clr(swrst),
        .clr_we(wr_en && addr == A_TXEOB), .wdata, .set_bits(tx_eob_bits), .q(tx_eob_q));
    dmac_w1c_status u_rxeob (.clk, .rst_n, .sw_clr(swrst),
        .clr_we(wr_en && addr == A_RXEOB), .wdata, .set_bits(rx_eob_bits), .q(rx_eob_q));
    dmac_w1c_status u_txder (.clk, .rst_n, .sw_clr(swrst),
        .clr_we(wr_en && addr == A_TXDER), .wdata, .set_bits(tx_der_bits), .q(tx_der_q));
    dmac_w1c_status u_rxder (.clk, .rst_n, .sw_clr(swrst),
        .clr_we(wr_en && addr == A_RXDER), .wdata, .set_bits(rx_der_bits), .q(rx_der_q));

    dmac_chan_bank #(.N(TXN), .BASE(A_TXPTR), .DMASK(FULL_WMASK)) u_txptr (
        .clk, .rst_n, .wr_en, .addr, .wdata, .hit(txp_hit), .rd_val(txp_val));
    dmac_chan_bank #(.N(RXN), .BASE(A_RXPTR), .DMASK(FULL_WMASK)) u_rxptr (
        .clk, .rst_n, .wr_en, .addr, .wdata, .hit(rxp_hit), .rd_val(rxp_val));
    dmac_chan_bank #(.N(RXN), .BASE(A_RXBSZ), .DMASK(BSZ_WMASK)) u_rxbsz (
        .clk, .rst_n, .wr_en, .addr, .wdata, .hit(bsz_hit), .rd_val(bsz_val));

    always_comb begin
        decoded = 1'b1;
        unique case (addr)
            A_CFG:   rd_mux = cfg_q;
            A_ERR:   rd_mux = err_q;
            A_IEN:   rd_mux = ien_q;
            A_TXSET: rd_mux = txset_q;
            A_TXCLR: rd_mux = txclr_q;
            A_TXEOB: rd_mux = tx_eob_q;
            A_TXDER: rd_mux = tx_der_q;
            A_RXSET: rd_mux = rxset_q;
            A_RXCLR: rd_mux = rxclr_q;
            A_RXEOB: rd_mux = rx_eob_q;
            A_RXDER: rd_mux = rx_der_q;
            default: begin
                decoded = txp_hit || rxp_hit || bsz_hit;
                rd_mux  = txp_val | rxp_val | bsz_val;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    assign irq_err    = (|err_q)    && ien_q[IE_ERR];
    assign irq_tx_eob = (|tx_eob_q) && ien_q[IE_TXEOB];
    assign irq_rx_eob = (|rx_eob_q) && ien_q[IE_RXEOB];
    assign irq_derr   = ((|tx_der_q) && ien_q[IE_TXDER]) ||
                        ((|rx_der_q) && ien_q[IE_RXDER]);
endmodule

// File: rtl/dmac_reg_block_chk.sv
module dmac_reg_block_chk
    import dmac_regs_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] wdata,
    input logic [DW-1:0] rdata,
    input logic [DW-1:0] cfg_q,
    input logic [DW-1:0] ien_q,
    input logic [DW-1:0] tx_eob_q,
    input logic [DW-1:0] tx_eob_bits,
    input logic [DW-1:0] err_set,
    input logic          irq_err,
    input logic          decoded
);
    // R3
    sw_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CFG && wdata[SWRST_BIT]) |=>
            (cfg_q == CFG_RST && ien_q == '0 && tx_eob_q == '0));

    // R2
    cfg_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CFG && !wdata[SWRST_BIT]) |=>
            (cfg_q == ($past(wdata) & CFG_WMASK)));

    // R6
    eob_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_TXEOB) |=>
            ((tx_eob_q & $past(wdata) & ~$past(tx_eob_bits)) == '0));

    // R10
    undecoded_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !decoded) |=> (rdata == '0));

    // R11
    irq_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_err) |-> $past(err_set != '0 || (wr_en && addr == A_IEN)));

    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && $past(rst_n)) |=> $stable(rdata));
endmodule

bind dmac_reg_block dmac_reg_block_chk u_chk (.*);

// File: tb/dmac_reg_block_tb.sv
module dmac_reg_block_tb;
    localparam int TXN = 4;
    localparam int RXN = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic           rd_en = 1'b0;
    logic [9:0]     addr = '0;
    logic [31:0]    wdata = '0;
    logic [31:0]    rdata;
    logic [TXN-1:0] tx_eob_set = '0;
    logic [RXN-1:0] rx_eob_set = '0;
    logic [TXN-1:0] tx_derr_set = '0;
    logic [RXN-1:0] rx_derr_set = '0;
    logic [31:0]    err_set = '0;
    logic           irq_err, irq_tx_eob, irq_rx_eob, irq_derr;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dmac_reg_block #(.TXN(TXN), .RXN(RXN)) u_dut (
        .clk, .rst_n, .wr_en, .rd_en, .addr, .wdata, .rdata,
        .tx_eob_set, .rx_eob_set, .tx_derr_set, .rx_derr_set, .err_set,
        .irq_err, .irq_tx_eob, .irq_rx_eob, .irq_derr);

    typedef struct packed {
        logic [7:0]  req;
        logic [9:0]  a;
        logic [31:0] d;
        logic [31:0] e;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{8'd4,  10'h182, 32'hFFFF_FFFF, 32'h0000_001F},  // R4
        '{8'd5,  10'h184, 32'hFFFF_FFFF, 32'hF000_0000},  // R5
        '{8'd5,  10'h185, 32'h1234_5678, 32'h1000_0000},  // R5
        '{8'd5,  10'h190, 32'hFFFF_FFFF, 32'hC000_0000},  // R5
        '{8'd5,  10'h191, 32'h7FFF_FFFF, 32'h4000_0000},  // R5
        '{8'd8,  10'h1A0, 32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R8
        '{8'd8,  10'h1A3, 32'h0123_4567, 32'h0123_4567},  // R8
        '{8'd8,  10'h1C1, 32'hCAFE_F00D, 32'hCAFE_F00D},  // R8
        '{8'd9,  10'h1E1, 32'hFFFF_FFAB, 32'h0000_00AB},  // R9
        '{8'd10, 10'h1A4, 32'hFFFF_FFFF, 32'h0000_0000},  // R10
        '{8'd10, 10'h1C2, 32'h1111_1111, 32'h0000_0000},  // R10
        '{8'd10, 10'h1E2, 32'h0000_00FF, 32'h0000_0000},  // R10
        '{8'd10, 10'h183, 32'hFFFF_FFFF, 32'h0000_0000},  // R10
        '{8'd2,  10'h180, 32'h7FFF_FFFF, 32'h00FF_C087},  // R2
        '{8'd6,  10'h186, 32'hFFFF_FFFF, 32'h0000_0000}   // R6
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 rdata after reset", rdata, 32'h0);
        chk("R1 irqs after reset", {28'h0, irq_err, irq_tx_eob, irq_rx_eob, irq_derr}, 32'h0);
        rd(10'h180, v); chk("R1 config reset", v, 32'h0007_C000);
        rd(10'h1A0, v); chk("R1 pointer reset", v, 32'h0);
        rd(10'h182, v); chk("R1 enable reset", v, 32'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            wr(VECS[i].a, VECS[i].d);
            rd(VECS[i].a, v);
            nchk++;
            if (v !== VECS[i].e) begin
                nfail++;
                $display("FAIL vector %0d R%0d addr=%h actual=%h expected=%h",
                         i, VECS[i].req, VECS[i].a, v, VECS[i].e);
            end
        end
        // R10 out-of-range writes left neighbours untouched
        rd(10'h1A3, v); chk("R10 neighbour pointer kept", v, 32'h0123_4567);

        // R6 event sets bit 31-c, raises interrupt (R11), W1C clears
        @(negedge clk); tx_eob_set = 4'b0010;
        @(negedge clk); tx_eob_set = '0;
        chk("R11 irq_tx_eob on event", {31'h0, irq_tx_eob}, 32'h1);
        chk("R11 irq_err quiet", {31'h0, irq_err}, 32'h0);
        rd(10'h186, v); chk("R6 tx eob bit30", v, 32'h4000_0000);
        wr(10'h186, 32'h4000_0000);
        chk("R11 irq_tx_eob after clear", {31'h0, irq_tx_eob}, 32'h0);
        rd(10'h186, v); chk("R6 tx eob cleared", v, 32'h0);

        // R6 set wins over clear in the same cycle
        @(negedge clk);
        addr = 10'h186; wdata = 32'h8000_0000; wr_en = 1'b1; tx_eob_set = 4'b0001;
        @(negedge clk);
        wr_en = 1'b0; tx_eob_set = '0;
        rd(10'h186, v); chk("R6 set beats clear", v, 32'h8000_0000);

        // R6 receive side
        @(negedge clk); rx_eob_set = 2'b01;
        @(negedge clk); rx_eob_set = '0;
        chk("R11 irq_rx_eob on event", {31'h0, irq_rx_eob}, 32'h1);
        rd(10'h192, v); chk("R6 rx eob bit31", v, 32'h8000_0000);

        // R7 error and descriptor-error status
        @(negedge clk); err_set = 32'h0000_0020; rx_derr_set = 2'b10;
        @(negedge clk); err_set = '0; rx_derr_set = '0;
        chk("R11 irq_err on set", {31'h0, irq_err}, 32'h1);
        chk("R11 irq_derr on rx derr", {31'h0, irq_derr}, 32'h1);
        rd(10'h181, v); chk("R7 error bit5", v, 32'h0000_0020);
        rd(10'h193, v); chk("R7 rx derr bit30", v, 32'h4000_0000);
        wr(10'h193, 32'hFFFF_FFFF);
        rd(10'h193, v); chk("R7 rx derr cleared", v, 32'h0);
        chk("R11 irq_derr after clear", {31'h0, irq_derr}, 32'h0);
        @(negedge clk); tx_derr_set = 4'b1000;
        @(negedge clk); tx_derr_set = '0;
        rd(10'h187, v); chk("R7 tx derr bit28", v, 32'h1000_0000);

        // R11 enable gating
        wr(10'h182, 32'h0000_0000);
        chk("R11 irq_tx_eob gated off", {31'h0, irq_tx_eob}, 32'h0);
        chk("R11 irq_err gated off", {31'h0, irq_err}, 32'h0);
        wr(10'h182, 32'h0000_0002);
        chk("R11 irq_tx_eob enabled", {31'h0, irq_tx_eob}, 32'h1);
        chk("R4 bit1 alone gates only tx eob", {31'h0, irq_rx_eob}, 32'h0);

        // R12 read data holds with rd_en low
        rd(10'h1C1, v);
        repeat (3) @(negedge clk);
        chk("R12 rdata holds", rdata, 32'hCAFE_F00D);

        // R3 software reset
        wr(10'h180, 32'h8000_0000);
        chk("R3 irq_tx_eob dropped", {31'h0, irq_tx_eob}, 32'h0);
        rd(10'h180, v); chk("R3 config reset value", v, 32'h0007_C000);
        rd(10'h182, v); chk("R3 enable cleared", v, 32'h0);
        rd(10'h184, v); chk("R3 tx active set cleared", v, 32'h0);
        rd(10'h191, v); chk("R3 rx active reset cleared", v, 32'h0);
        rd(10'h186, v); chk("R3 tx eob cleared", v, 32'h0);
        rd(10'h181, v); chk("R3 error cleared", v, 32'h0);
        rd(10'h1A0, v); chk("R3 pointer kept", v, 32'hDEAD_BEEF);
        rd(10'h1E1, v); chk("R3 buffer size kept", v, 32'h0000_00AB);

        done = 1'b1;
        summary();
    end
endmodule